// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This peripheral holds two identical down-counters behind a small word-addressed register bus. Software writes a reload value and a control word to each counter. The control word enables it, picks periodic or one-shot operation and picks a clock divider of 1, 16 or 256. The counter then decrements once per divided tick.

When a counter steps from one to zero it raises a sticky pending flag. A periodic counter reloads itself on the following tick. A one-shot counter parks at zero and switches itself off. Any write to a counter's clear register drops its pending flag. The block drives one interrupt line, the OR of both flags. Reads are combinational, so the data for an address appears in the same cycle as the request.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register of both counters reads zero, both counters are disabled and `irq` is low.
- R2: Byte address bit 5 selects the counter (0x00 for the first, 0x20 for the second). Within a counter, offset 0x0 is reload, 0x4 is live count, 0x8 is control and 0xC is pending/clear. Address bits [1:0] are ignored. Offsets 0x10–0x1F and 0x30–0x3F read as zero and ignore writes.
- R3: A reload write stores the low 24 bits, copies them into the live count at once and restarts the divider phase. Bits above 23 are dropped, and both registers read back zero-extended.
- R4: Control bit 7 is enable and bit 6 is periodic. Bits [3:2] pick the divider: 0 gives 1, 1 gives 16, and 2 or 3 give 256. Only these four bits read back; all other bits read zero.
- R5: While enabled, the live count drops by one per divided tick. Counting from the clock edge that applies a control or reload write, the first tick comes 1, 16 or 256 edges later, then every 1, 16 or 256 edges after that.
- R6: A tick that moves the count from 1 to 0 sets the counter's pending flag. In periodic mode the next tick reloads the count from the reload register. In one-shot mode the count stays at zero and the enable bit clears.
- R7: Any write to offset 0xC clears that counter's pending flag, whatever the data. Reading 0xC returns the flag in bit 0. If the flag is being set in the same cycle, the set wins.
- R8: `irq` is high exactly when either counter's pending flag is set.
- R9: Read data is combinational: `bus_rdata` shows the addressed register during the cycle in which `bus_en` is high and `bus_we` is low. With no read it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Combined interrupt |

## Verification
A write takes effect at the edge that ends its cycle. In divide-by-1 the first decrement lands one edge later. In divide-by-16 and divide-by-256 it lands 16 or 256 edges after the applying edge. The pending flag and `irq` change at the same edge that brings the count to zero. Every read in the bench takes two edges, and fixed idle gaps are inserted, so each sample falls at a known edge offset from the enabling write. The monitor compares values in the low clock phase, after the read mux has settled. One clear write is placed on purpose on the edge where a periodic count reaches zero, to show that the set wins.

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int CW = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int NT = 2;

  logic [CW-1:0] ld   [NT];
  logic [CW-1:0] cnt  [NT];
  logic [1:0]    psel [NT];
  logic [7:0]    pc   [NT];
  logic [NT-1:0] en, per, pend;
  logic [NT-1:0] tick, wld, wctl, wclr;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      wld[i]  = bus_en && bus_we && !bus_addr[4] && (bus_addr[5] == 1'(i)) && (bus_addr[3:2] == 2'd0);
      wctl[i] = bus_en && bus_we && !bus_addr[4] && (bus_addr[5] == 1'(i)) && (bus_addr[3:2] == 2'd2);
      wclr[i] = bus_en && bus_we && !bus_addr[4] && (bus_addr[5] == 1'(i)) && (bus_addr[3:2] == 2'd3);
      case (psel[i])
        2'd0:    tick[i] = en[i];
        2'd1:    tick[i] = en[i] && (pc[i][3:0] == 4'hf);
        default: tick[i] = en[i] && (pc[i] == 8'hff);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        ld[i]   <= '0;
        cnt[i]  <= '0;
        psel[i] <= '0;
        pc[i]   <= '0;
      end
      en   <= '0;
      per  <= '0;
      pend <= '0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (!en[i] || wld[i] || wctl[i]) pc[i] <= '0;
        else                             pc[i] <= pc[i] + 8'd1;

        if (wclr[i]) pend[i] <= 1'b0;

        if (tick[i]) begin
          if (cnt[i] != '0) begin
            cnt[i] <= cnt[i] - 1'b1;
            if (cnt[i] == CW'(1)) begin
              pend[i] <= 1'b1;
              if (!per[i]) en[i] <= 1'b0;
            end
          end else if (per[i]) begin
            cnt[i] <= ld[i];
          end
        end

        if (wld[i]) begin
          ld[i]  <= bus_wdata[CW-1:0];
          cnt[i] <= bus_wdata[CW-1:0];
        end

        if (wctl[i]) begin
          en[i]   <= bus_wdata[7];
          per[i]  <= bus_wdata[6];
          psel[i] <= bus_wdata[3:2];
        end
      end
    end
  end

  logic t;
  assign t = bus_addr[5];

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we && !bus_addr[4]) begin
      case (bus_addr[3:2])
        2'd0: bus_rdata = 32'(ld[t]);
        2'd1: bus_rdata = 32'(cnt[t]);
        2'd2: bus_rdata = {24'd0, en[t], per[t], 2'b00, psel[t], 2'b00};
        2'd3: bus_rdata = {31'd0, pend[t]};
      endcase
    end
  end

  assign irq = |pend;
endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [5:0]    bus_addr,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic [1:0]    en,
  input logic [1:0]    pend
);
  logic ldwr0, ctlwr0, clrwr0;
  assign ldwr0  = bus_en && bus_we && (bus_addr[5:2] == 4'b0000);
  assign ctlwr0 = bus_en && bus_we && (bus_addr[5:2] == 4'b0010);
  assign clrwr0 = bus_en && bus_we && (bus_addr[5:2] == 4'b0011);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt0 != $past(cnt0)) && !$past(ldwr0)) |->
      ((cnt0 == $past(cnt0) - CW'(1)) || ($past(cnt0) == '0)));

  a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en[0]) && !$past(ctlwr0)) |-> (cnt0 == '0));

  a_r6_pend_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> ((cnt0 == '0) && ($past(cnt0) == CW'(1))));

  a_r6_pend_on_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[1]) |-> ((cnt1 == '0) && ($past(cnt1) == CW'(1))));

  a_r7_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
    clrwr0 |=> (!pend[0] || ((cnt0 == '0) && ($past(cnt0) == CW'(1)))));
endmodule

bind dual_down_timer dual_down_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .cnt0(cnt[0]), .cnt1(cnt[1]), .en(en), .pend(pend)
);

// File: tb/tb_dual_down_timer.sv
module tb_dual_down_timer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    logic [31:0] exp;
    bit          chk_irq;
    logic        exp_irq;
  } item_t;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  dual_down_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string r,
                    input bit ci = 1'b0, input logic ei = 1'b0);
    item_t it;
    it.req = r; it.exp = e; it.chk_irq = ci; it.exp_irq = ei;
    @(posedge clk); #1;
    q.push_back(it);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (bus_en && !bus_we) begin
      item_t it;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
      end else begin
        it = q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: addr %h rdata actual %h expected %h", it.req, bus_addr, bus_rdata, it.exp);
        end
        if (it.chk_irq) begin
          checks++;
          if (irq !== it.exp_irq) begin
            errors++;
            $display("FAIL %s: irq actual %b expected %b", it.req, irq, it.exp_irq);
          end
        end
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(6'(4*i), 32'h0, "R1", 1'b1, 1'b0);
      rd(6'(6'h20 + 4*i), 32'h0, "R1");
    end

    // R3 reload write copies to count, drops upper bits; R2 second bank
    wr(6'h00, 32'hFF00_0010);
    rd(6'h00, 32'h10, "R3");
    rd(6'h04, 32'h10, "R3");
    wr(6'h20, 32'h0012_3456);
    rd(6'h20, 32'h0012_3456, "R2");
    rd(6'h25, 32'h0012_3456, "R2");

    // R4 control readback masks
    wr(6'h28, 32'hFFFF_FF3F);
    rd(6'h28, 32'h0000_000C, "R4");

    // R5/R6 one-shot divide-by-1
    wr(6'h00, 32'd5);
    wr(6'h08, 32'h80);
    rd(6'h04, 32'd4, "R5");
    rd(6'h04, 32'd2, "R5");
    rd(6'h04, 32'd0, "R6", 1'b1, 1'b1);
    rd(6'h08, 32'h0, "R6");
    rd(6'h04, 32'd0, "R6");
    rd(6'h0C, 32'd1, "R7");

    // R7 clear by any data
    wr(6'h0C, 32'h0);
    rd(6'h0C, 32'd0, "R7", 1'b1, 1'b0);

    // R6 periodic and R7 set beats clear, second counter
    wr(6'h20, 32'd3);
    wr(6'h28, 32'hC0);
    rd(6'h24, 32'd2, "R5");
    rd(6'h24, 32'd0, "R6", 1'b1, 1'b1);
    idle(1);
    wr(6'h2C, 32'hDEAD_BEEF);
    rd(6'h2C, 32'd1, "R7");
    rd(6'h24, 32'd1, "R6");
    wr(6'h28, 32'h0);
    wr(6'h2C, 32'h1);
    rd(6'h2C, 32'd0, "R7", 1'b1, 1'b0);

    // R5 divide-by-16 one-shot
    wr(6'h00, 32'd2);
    wr(6'h08, 32'h84);
    idle(13);
    rd(6'h04, 32'd2, "R5");
    rd(6'h04, 32'd1, "R5");
    idle(13);
    rd(6'h04, 32'd1, "R5");
    rd(6'h04, 32'd0, "R6", 1'b1, 1'b1);
    rd(6'h08, 32'h04, "R6");

    // R4 divider code 3 acts as 256
    wr(6'h20, 32'd1);
    wr(6'h28, 32'h8C);
    idle(253);
    rd(6'h24, 32'd1, "R4");
    rd(6'h24, 32'd0, "R4", 1'b1, 1'b1);
    rd(6'h28, 32'h0C, "R6");

    // R8 interrupt is OR of both flags
    wr(6'h2C, 32'h0);
    rd(6'h2C, 32'd0, "R8", 1'b1, 1'b1);
    wr(6'h0C, 32'h0);
    rd(6'h0C, 32'd0, "R8", 1'b1, 1'b0);

    // R2 unmapped window ignored
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h34, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0, "R2");
    rd(6'h34, 32'h0, "R2");
    rd(6'h00, 32'd2, "R2");
    rd(6'h08, 32'h04, "R2");

    // R9 no read gives zero
    @(posedge clk); #1;
    bus_addr = 6'h00;
    @(negedge clk);
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R9: idle rdata actual %h expected %h", bus_rdata, 32'h0);
    end

    idle(2);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending items actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule